// File: doc/BRIEF.md
# DMA Bus Hold-Time Limiter

This block sits between a multi-channel DMA engine and a shared system bus whose arbiter has no priorities. Once the DMA wins the bus, no other master can get it until the DMA lets go. This block stops a long transfer from locking out other masters such as a display refresh engine. It counts how long the DMA has held the bus. When a programmed limit is reached, it withdraws the bus request in the middle of the transfer. It then stays off the bus for a fixed gap and requests the bus again so that the rest of the transfer can go ahead.

Software sets the block up through a small register port. One register holds a mask that enables each channel. A second holds the limiter switch and the hold limit, which is counted in units of 256 clock cycles. A third holds a software-start flag for each channel. The channels' pending lines, masked by the enable register and combined with the software-start flags, form the bus demand. A single counter measures the hold time for all channels together. The `forced_release` output pulses in the cycle where the limit is reached.

Top module: `bus_occ_limiter`

## Requirements
- R1: Address 0 is the channel-enable register. Bit n enables channel n for n = 0..5. Bits 7:6 always read 0, and all bits are 0 after reset.
- R2: Address 1 is the limiter register, with the enable switch at bit 7 and the hold limit at bits 6:0. Address 2 holds the software-start flags, one bit per channel at bit n. Address 3 reads 0. Every register is 0 after reset.
- R3: `bus_req` is high in the same cycle whenever an enabled channel has its pending line or its software-start flag set, except during a back-off gap. Pending lines of disabled channels have no effect.
- R4: No forced release ever happens while the limiter switch is 0 or the hold limit is 0.
- R5: With the limiter armed and the limit set to V, `forced_release` pulses in the V×256-th consecutive cycle in which `bus_req` and `bus_gnt` are both high. `bus_req` is low in the following cycle.
- R6: After a forced release, `bus_req` stays low for exactly 16 cycles. In the 17th cycle it rises again if demand remains.
- R7: A single hold counter is shared by all channels. Handing the bus from one enabled channel to another without a break in demand does not restart the count.
- R8: Writes to the limiter register are ignored while any channel-enable bit is 1. They take effect while the enable register is 0.
- R9: Every forced release clears all software-start flags. A flag-only demand therefore ends after the release.
- R10: The hold count restarts from zero each time the grant is newly obtained. A transfer that ends before the limit is followed by no back-off gap, so a new demand raises `bus_req` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ch_pending | input | 6 | Per-channel transfer-pending lines from the DMA |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| dma_go | output | 1 | DMA may drive the bus in this cycle |
| forced_release | output | 1 | One-cycle pulse when the hold limit is reached |

## Verification
The limiter is tested with several kinds of demand:
- A single channel holding the bus continuously. This pins the exact release cycle and the 16-cycle gap.
- A handover from one channel to another. This shows that the counter is shared rather than kept per channel.
- A transfer that stops early and starts again. This separates a restarted count from an accumulated one and shows that no gap follows a normal release.
- A demand made only by a software-start flag. This shows that the release clears the flag.
- Random enable masks, pending patterns that include disabled channels, and limits of 1 to 3 units. These check the masking and the exact V×256 count at more than one limit.

The zero limit, the limiter switched off, and writes to the limiter register while channels are enabled are tested as directed cases.

// File: rtl/occlim_pkg.sv
package occlim_pkg;

  localparam int REG_DW = 8;

  typedef enum logic [1:0] {
    RA_CHEN  = 2'd0,
    RA_TIMER = 2'd1,
    RA_SWST  = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;

  // Number of granted cycles after which a release is forced.
  function automatic int unsigned occ_limit_cycles(input int unsigned units,
                                                   input int unsigned pre_w);
    return units << pre_w;
  endfunction

endpackage

// File: rtl/occ_regs.sv
module occ_regs
  import occlim_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int VAL_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              force_clr,
  output logic [NUM_CH-1:0] chan_en,
  output logic              tmr_en,
  output logic [VAL_W-1:0]  tmr_val,
  output logic [NUM_CH-1:0] sw_start,
  output logic [REG_DW-1:0] rdata
);

  logic wr_chen, wr_tmr, wr_sw, tmr_locked;

  assign tmr_locked = |chan_en;
  assign wr_chen    = wr && (reg_addr_e'(addr) == RA_CHEN);
  assign wr_tmr     = wr && (reg_addr_e'(addr) == RA_TIMER) && !tmr_locked;
  assign wr_sw      = wr && (reg_addr_e'(addr) == RA_SWST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chan_en <= '0;
    else if (wr_chen) chan_en <= wdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_en  <= 1'b0;
      tmr_val <= '0;
    end else if (wr_tmr) begin
      tmr_en  <= wdata[REG_DW-1];
      tmr_val <= wdata[VAL_W-1:0];
    end
  end

  // One start flag per channel; a forced release wins over a write.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_sw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sw_start[i] <= 1'b0;
      else if (force_clr) sw_start[i] <= 1'b0;
      else if (wr_sw)     sw_start[i] <= wdata[i];
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      RA_CHEN:  rdata[NUM_CH-1:0] = chan_en;
      RA_TIMER: begin
        rdata[REG_DW-1]  = tmr_en;
        rdata[VAL_W-1:0] = tmr_val;
      end
      RA_SWST:  rdata[NUM_CH-1:0] = sw_start;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/occ_hold_timer.sv
module occ_hold_timer #(
  parameter int VAL_W = 7,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_active,
  input  logic             limit_on,
  input  logic [VAL_W-1:0] tmr_val,
  output logic [PRE_W-1:0] pre_cnt,
  output logic [VAL_W-1:0] unit_cnt,
  output logic             limit_hit
);

  function automatic logic last_unit(input logic [VAL_W-1:0] units,
                                     input logic [VAL_W-1:0] lim);
    return units == (lim - VAL_W'(1));
  endfunction

  logic pre_wrap;
  assign pre_wrap = &pre_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else if (!hold_active) begin
      pre_cnt  <= '0;
      unit_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
      if (pre_wrap) unit_cnt <= unit_cnt + VAL_W'(1);
    end
  end

  assign limit_hit = limit_on && hold_active && pre_wrap && last_unit(unit_cnt, tmr_val);

endmodule

// File: rtl/occ_backoff.sv
module occ_backoff #(
  parameter int GAP = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);

  localparam int BW = $clog2(GAP + 1);

  logic [BW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left <= '0;
    else if (start)          left <= BW'(GAP);
    else if (left != '0)     left <= left - BW'(1);
  end

  assign active = (left != '0);

endmodule

// File: rtl/bus_occ_limiter.sv
module bus_occ_limiter
  import occlim_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int VAL_W  = 7,
  parameter int PRE_W  = 8,
  parameter int GAP    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NUM_CH-1:0] ch_pending,
  input  logic              bus_gnt,
  output logic              bus_req,
  output logic              dma_go,
  output logic              forced_release
);

  logic [NUM_CH-1:0] chan_en, sw_start;
  logic              tmr_en, limit_on, demand, hold_active, in_backoff, limit_hit;
  logic [VAL_W-1:0]  tmr_val, unit_cnt;
  logic [PRE_W-1:0]  pre_cnt;

  occ_regs #(.NUM_CH(NUM_CH), .VAL_W(VAL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .force_clr(limit_hit), .chan_en(chan_en), .tmr_en(tmr_en), .tmr_val(tmr_val),
    .sw_start(sw_start), .rdata(reg_rdata)
  );

  assign limit_on    = tmr_en && (tmr_val != '0);
  assign demand      = |((ch_pending | sw_start) & chan_en);
  assign bus_req     = demand && !in_backoff;
  assign hold_active = bus_req && bus_gnt;

  occ_hold_timer #(.VAL_W(VAL_W), .PRE_W(PRE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .hold_active(hold_active), .limit_on(limit_on),
    .tmr_val(tmr_val), .pre_cnt(pre_cnt), .unit_cnt(unit_cnt), .limit_hit(limit_hit)
  );

  occ_backoff #(.GAP(GAP)) u_backoff (
    .clk(clk), .rst_n(rst_n), .start(limit_hit), .active(in_backoff)
  );

  assign dma_go         = hold_active;
  assign forced_release = limit_hit;

endmodule

// File: rtl/occ_limiter_chk.sv
module occ_limiter_chk
  import occlim_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int VAL_W  = 7,
  parameter int PRE_W  = 8,
  parameter int GAP    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              forced_release,
  input logic [NUM_CH-1:0] chan_en,
  input logic [NUM_CH-1:0] sw_start,
  input logic              tmr_en,
  input logic [VAL_W-1:0]  tmr_val,
  input logic [PRE_W-1:0]  pre_cnt,
  input logic [VAL_W-1:0]  unit_cnt
);

  localparam int GW = $clog2(GAP + 1);

  logic [GW-1:0] gap_left;
  logic [31:0]   held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_left <= '0;
    else if (forced_release)   gap_left <= GW'(GAP);
    else if (gap_left != '0)   gap_left <= gap_left - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    held <= '0;
    else if (bus_req && bus_gnt)   held <= held + 32'd1;
    else                           held <= '0;
  end

  a_r4_no_release_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmr_en || tmr_val == '0) |-> !forced_release);

  a_r5_exact_limit: assert property (@(posedge clk) disable iff (!rst_n)
    forced_release |-> (held + 32'd1 == occ_limit_cycles(32'(tmr_val), PRE_W)));

  a_r5_release_while_held: assert property (@(posedge clk) disable iff (!rst_n)
    forced_release |-> (bus_req && bus_gnt));

  a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    forced_release |=> !bus_req);

  a_r6_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_left != '0) |-> !bus_req);

  a_r8_timer_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_en) |=> $stable({tmr_en, tmr_val}));

  a_r9_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    forced_release |=> (sw_start == '0));

  a_r10_count_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |=> (pre_cnt == '0 && unit_cnt == '0));

endmodule

bind bus_occ_limiter occ_limiter_chk #(
  .NUM_CH(NUM_CH), .VAL_W(VAL_W), .PRE_W(PRE_W), .GAP(GAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .forced_release(forced_release), .chan_en(chan_en), .sw_start(sw_start),
  .tmr_en(tmr_en), .tmr_val(tmr_val), .pre_cnt(pre_cnt), .unit_cnt(unit_cnt)
);

// File: tb/bus_occ_limiter_bench.sv
`timescale 1ns/1ps
module bus_occ_limiter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [5:0] ch_pending = 6'd0;
  logic       bus_gnt;
  logic       bus_req, dma_go, forced_release;

  int checks = 0;
  int errors = 0;
  int hold_run = 0;

  localparam logic [1:0] A_EN = 2'd0, A_TMR = 2'd1, A_SW = 2'd2, A_NONE = 2'd3;

  always #5 clk = ~clk;

  bus_occ_limiter u_bus_occ_limiter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_pending(ch_pending),
    .bus_gnt(bus_gnt), .bus_req(bus_req), .dma_go(dma_go),
    .forced_release(forced_release)
  );

  // Arbiter model: grant follows request one cycle later.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req;
  end

  // Consecutive fully granted cycles before the current one.
  always @(posedge clk) begin
    if (bus_req && bus_gnt) hold_run <= hold_run + 1;
    else                    hold_run <= 0;
  end

  function automatic int exp_limit(input int units);
    return units * 256;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic teardown();
    @(posedge clk); #1;
    ch_pending = 6'd0;
    wr_reg(A_EN, 8'h00);
    wr_reg(A_SW, 8'h00);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Waits for a forced release; reports the granted-cycle index at the pulse.
  task automatic wait_release(input int timeout, output bit seen, output int run);
    seen = 1'b0; run = 0;
    for (int i = 0; i < timeout; i++) begin
      @(negedge clk);
      if (forced_release) begin
        seen = 1'b1;
        run  = hold_run + 1;
        break;
      end
    end
  endtask

  // Counts cycles with bus_req low after a release pulse.
  task automatic measure_gap(output int gap);
    gap = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!bus_req) gap++;
      else break;
    end
  endtask

  task automatic wait_held(input int n);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (bus_req && bus_gnt && hold_run + 1 >= n) break;
    end
  endtask

  task automatic count_pulses(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (forced_release) pulses++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit seen;
    int run, gap, pulses;
    void'($urandom(32'd2024));

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);

    // R1/R2 reset state
    rd_reg(A_EN, d);   check("R1 enable reset", d, 0);
    rd_reg(A_TMR, d);  check("R2 limiter reset", d, 0);
    rd_reg(A_SW, d);   check("R2 flags reset", d, 0);
    check("R3 no request after reset", bus_req, 0);
    check("R5 no pulse after reset", forced_release, 0);

    // R1 upper bits read zero; R2 unused address
    wr_reg(A_EN, 8'hFF);
    rd_reg(A_EN, d);   check("R1 enable bits 7:6 read 0", d, 8'h3F);
    wr_reg(A_NONE, 8'hFF);
    rd_reg(A_NONE, d); check("R2 address 3 reads 0", d, 0);
    wr_reg(A_EN, 8'h00);

    // R3 masking of disabled channels
    ch_pending = 6'h3F; #1;
    @(negedge clk);
    check("R3 disabled channels ignored", bus_req, 0);
    ch_pending = 6'h00;

    // R8 limiter writes ignored while enabled
    wr_reg(A_TMR, 8'h81);
    wr_reg(A_EN, 8'h01);
    wr_reg(A_TMR, 8'h83);
    rd_reg(A_TMR, d);  check("R8 write ignored when enabled", d, 8'h81);
    wr_reg(A_EN, 8'h00);
    wr_reg(A_TMR, 8'h83);
    rd_reg(A_TMR, d);  check("R8 write accepted when idle", d, 8'h83);

    // R4 zero limit with switch on
    wr_reg(A_TMR, 8'h80);
    ch_pending = 6'h01;
    wr_reg(A_EN, 8'h01);
    count_pulses(1200, pulses);
    check("R4 zero limit never releases", pulses, 0);
    check("R4 request still held", bus_req, 1);
    teardown();

    // R4 switch off with nonzero limit
    wr_reg(A_TMR, 8'h02);
    ch_pending = 6'h02;
    wr_reg(A_EN, 8'h02);
    count_pulses(1200, pulses);
    check("R4 switch off never releases", pulses, 0);
    teardown();

    // R5/R6 limit of one unit
    wr_reg(A_TMR, 8'h81);
    ch_pending = 6'h01;
    wr_reg(A_EN, 8'h01);
    wait_release(3000, seen, run);
    check("R5 release seen", seen, 1);
    check("R5 release at 256 cycles", run, exp_limit(1));
    measure_gap(gap);
    check("R6 gap length", gap, 16);
    check("R6 request resumes", bus_req, 1);
    teardown();

    // R10 early end, no gap, count restarts
    wr_reg(A_TMR, 8'h81);
    ch_pending = 6'h01;
    wr_reg(A_EN, 8'h01);
    wait_held(100);
    @(posedge clk); #1 ch_pending = 6'h00;
    @(negedge clk);
    check("R3 request drops with demand", bus_req, 0);
    repeat (3) @(posedge clk);
    #1 ch_pending = 6'h01;
    @(negedge clk);
    check("R10 no gap after normal end", bus_req, 1);
    wait_release(3000, seen, run);
    check("R10 count restarted", run, exp_limit(1));
    teardown();

    // R7 shared counter across a channel handover
    wr_reg(A_TMR, 8'h82);
    ch_pending = 6'h01;
    wr_reg(A_EN, 8'h09);
    wait_held(100);
    @(posedge clk); #1 ch_pending = 6'h09;
    @(posedge clk); #1 ch_pending = 6'h08;
    wait_release(3000, seen, run);
    check("R7 shared count over handover", run, exp_limit(2));
    teardown();

    // R9 software start flag cleared by forced release
    wr_reg(A_TMR, 8'h81);
    wr_reg(A_EN, 8'h04);
    wr_reg(A_SW, 8'h04);
    rd_reg(A_SW, d);   check("R9 flag set", d, 8'h04);
    wait_release(3000, seen, run);
    check("R9 release from flag demand", run, exp_limit(1));
    @(posedge clk);
    rd_reg(A_SW, d);   check("R9 flag cleared", d, 0);
    repeat (30) @(negedge clk);
    check("R9 no demand after clear", bus_req, 0);
    teardown();

    // Random patterns: R3 masking, R5 exact limit, R6 gap
    for (int k = 0; k < 10; k++) begin
      int units;
      logic [5:0] en, pend;
      units = 1 + int'($urandom % 3);
      en    = 6'($urandom);
      if (en == 6'd0) en = 6'd1;
      pend  = (en & 6'($urandom)) | (~en & 6'($urandom));
      if ((pend & en) == 6'd0) pend = pend | (en & (~en + 6'd1));
      wr_reg(A_TMR, 8'h80 | 8'(units));
      ch_pending = pend;
      wr_reg(A_EN, {2'b00, en});
      wait_release(4000, seen, run);
      check("R5 random release cycle", run, exp_limit(units));
      measure_gap(gap);
      check("R6 random gap", gap, 16);
      teardown();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule